// File: doc/BRIEF.md
# H-Bridge Gate Sequencer with Dead Time

This block drives the four switches of one full H-bridge: a high-side and a low-side switch on the left leg, and the same pair on the right leg. Each clock cycle it takes a requested bridge mode and a current-polarity bit. The modes are charge, slow decay and fast decay. From these it produces the four gate enables, and all four are registered.

The switch patterns for charge and fast decay are mirror images between the two polarities. Slow decay is the same for both. Any change of the request passes through an all-off interval of `DEAD_CYC` clock cycles before the new pattern appears. This covers a change of mode, a change of polarity alone, or a new change made while the interval is still running.

A low output enable turns all gates off. A thermal-fault input does the same and also pulls an active-low protect output low. The block keeps following the request while it is forced off, so a pending dead time still runs out during that period.

Top module: `hbridge_gate_seq`

## Requirements
- R1: With `pol_neg`=0, the gate vector {hs_left, hs_right, ls_left, ls_right} is 1001 for mode code 2'b00 (charge), 0011 for code 2'b01 (slow decay) and 0110 for code 2'b10 (fast decay).
- R2: With `pol_neg`=1, the gate vector is 0110 for charge, 0011 for slow decay and 1001 for fast decay.
- R3: Mode code 2'b11 drives the slow-decay pattern 0011 under either polarity. It is still a distinct request, so a change to or from it receives the dead time.
- R4: Suppose the request {mode_req, pol_neg} is changed before clock edge k. The gates are all off after edges k through k+DEAD_CYC-1, and they show the new pattern after edge k+DEAD_CYC. The old pattern stays visible until edge k.
- R5: A change of polarity alone, with the same mode, receives the same dead time as a mode change.
- R6: A request change made during a running dead time restarts the full DEAD_CYC interval, counted from the latest change.
- R7: With `out_en` low, all gates are off from the next edge. Requests are still tracked and their dead time still elapses. When `out_en` returns high with a settled request, the pattern reappears at the next edge.
- R8: With `fault` high, all gates are off and `prot_n` is low from the next edge. After `fault` falls, `prot_n` returns high at the next edge and a settled pattern resumes at that edge.
- R9: The high-side and low-side switch of the same leg are never on in the same cycle.
- R10: In reset, all gates are off and `prot_n` is high. After reset is released, the first request is held off for DEAD_CYC cycles like any other change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_req | input | 2 | Requested bridge mode: 00 charge, 01 slow decay, 10 fast decay, 11 slow decay |
| pol_neg | input | 1 | Current polarity: 0 positive, 1 negative |
| out_en | input | 1 | Output enable; low forces all gates off |
| fault | input | 1 | Thermal-fault input, active high |
| hs_left | output | 1 | Left-leg high-side gate enable |
| hs_right | output | 1 | Right-leg high-side gate enable |
| ls_left | output | 1 | Left-leg low-side gate enable |
| ls_right | output | 1 | Right-leg low-side gate enable |
| prot_n | output | 1 | Protect status, low while a fault is seen |

## Verification
The assertions assume that `mode_req`, `pol_neg`, `out_en` and `fault` are synchronous to `clk`. This means any thermal comparator output has already been synchronised before it reaches the block. The bench meets this by changing every input only on the falling clock edge and sampling outputs there as well, so each rising edge sees stable values. The one-edge response of the enable and fault gating, and the exact length of the all-off interval, are checked under that assumption.

// File: rtl/hbg_pkg.sv
package hbg_pkg;

  typedef enum logic [1:0] {
    BM_CHARGE = 2'b00,
    BM_SLOW   = 2'b01,
    BM_FAST   = 2'b10,
    BM_SLOW_X = 2'b11
  } bridge_mode_t;

  typedef struct packed {
    bridge_mode_t mode;
    logic         neg;
  } bridge_req_t;

  // gate vector order: {hs_left, hs_right, ls_left, ls_right}
  localparam int GATE_W = 4;
  localparam logic [GATE_W-1:0] GV_OFF   = 4'b0000;
  localparam logic [GATE_W-1:0] GV_DIAG  = 4'b1001;
  localparam logic [GATE_W-1:0] GV_ANTI  = 4'b0110;
  localparam logic [GATE_W-1:0] GV_LOWS  = 4'b0011;

endpackage

// File: rtl/hbg_pattern_dec.sv
module hbg_pattern_dec
  import hbg_pkg::*;
(
  input  bridge_req_t              req,
  output logic [GATE_W-1:0]        gates
);

  always_comb begin
    unique case (req.mode)
      BM_CHARGE: gates = req.neg ? GV_ANTI : GV_DIAG;
      BM_FAST:   gates = req.neg ? GV_DIAG : GV_ANTI;
      default:   gates = GV_LOWS;
    endcase
  end

endmodule

// File: rtl/hbg_dead_timer.sv
module hbg_dead_timer
  import hbg_pkg::*;
#(
  parameter int DEAD_CYC = 30
) (
  input  logic        clk,
  input  logic        rst,
  input  bridge_req_t req,
  output bridge_req_t act,
  output logic        settled
);

  localparam int CNT_W = (DEAD_CYC > 1) ? $clog2(DEAD_CYC) : 1;
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(DEAD_CYC - 1);

  logic [CNT_W-1:0] cnt;
  logic             act_vld;
  logic             changed;

  assign changed = !act_vld || (req != act);
  assign settled = !changed && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      act     <= '{mode: BM_SLOW, neg: 1'b0};
      act_vld <= 1'b0;
      cnt     <= LOAD;
    end else if (changed) begin
      act     <= req;
      act_vld <= 1'b1;
      cnt     <= LOAD;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  // a fresh request is never reported settled on the following cycle when more than one off cycle is due
  generate
    if (DEAD_CYC > 1) begin : g_hold_chk
      assert_change_holds_off_R6: assert property (@(posedge clk) disable iff (rst)
        (act_vld && (req != act)) |=> !settled);
    end
  endgenerate

endmodule

// File: rtl/hbg_gate_stage.sv
module hbg_gate_stage
  import hbg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              settled,
  input  logic [GATE_W-1:0] pattern,
  input  logic              out_en,
  input  logic              fault,
  output logic [GATE_W-1:0] gates_q,
  output logic              prot_n
);

  localparam int LEGS = 2;

  always_ff @(posedge clk) begin
    if (rst) begin
      gates_q <= GV_OFF;
      prot_n  <= 1'b1;
    end else begin
      gates_q <= (settled && out_en && !fault) ? pattern : GV_OFF;
      prot_n  <= !fault;
    end
  end

  // leg g: high side at bit 3-g, low side at bit 1-g
  generate
    for (genvar g = 0; g < LEGS; g++) begin : g_leg
      assert_no_shoot_R9: assert property (@(posedge clk) disable iff (rst)
        !(gates_q[3-g] && gates_q[1-g]));
    end
  endgenerate

  assert_pattern_via_off_R4: assert property (@(posedge clk) disable iff (rst)
    (gates_q != GV_OFF) |=> ((gates_q == GV_OFF) || $stable(gates_q)));

  assert_enable_off_R7: assert property (@(posedge clk) disable iff (rst)
    !out_en |=> (gates_q == GV_OFF));

  assert_fault_off_R8: assert property (@(posedge clk) disable iff (rst)
    fault |=> ((gates_q == GV_OFF) && !prot_n));

  assert_protect_clear_R8: assert property (@(posedge clk) disable iff (rst)
    !fault |=> prot_n);

endmodule

// File: rtl/hbridge_gate_seq.sv
module hbridge_gate_seq
  import hbg_pkg::*;
#(
  parameter int DEAD_CYC = 30
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode_req,
  input  logic       pol_neg,
  input  logic       out_en,
  input  logic       fault,
  output logic       hs_left,
  output logic       hs_right,
  output logic       ls_left,
  output logic       ls_right,
  output logic       prot_n
);

  bridge_req_t       req;
  bridge_req_t       act;
  logic              settled;
  logic [GATE_W-1:0] pattern;
  logic [GATE_W-1:0] gates_q;

  assign req = '{mode: bridge_mode_t'(mode_req), neg: pol_neg};

  hbg_dead_timer #(.DEAD_CYC(DEAD_CYC)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .req     (req),
    .act     (act),
    .settled (settled)
  );

  hbg_pattern_dec u_dec (
    .req   (act),
    .gates (pattern)
  );

  hbg_gate_stage u_stage (
    .clk     (clk),
    .rst     (rst),
    .settled (settled),
    .pattern (pattern),
    .out_en  (out_en),
    .fault   (fault),
    .gates_q (gates_q),
    .prot_n  (prot_n)
  );

  assign {hs_left, hs_right, ls_left, ls_right} = gates_q;

endmodule

// File: tb/tb_hbridge_gate_seq.sv
module tb_hbridge_gate_seq;

  localparam int CLK_PERIOD = 10;
  localparam int DEAD       = 30;

  logic       clk = 1'b0;
  logic       rst;
  logic [1:0] mode_req;
  logic       pol_neg;
  logic       out_en;
  logic       fault;
  logic       hs_left, hs_right, ls_left, ls_right, prot_n;

  int checks = 0;
  int errors = 0;
  int shoot_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hbridge_gate_seq #(.DEAD_CYC(DEAD)) dut (
    .clk(clk), .rst(rst), .mode_req(mode_req), .pol_neg(pol_neg),
    .out_en(out_en), .fault(fault),
    .hs_left(hs_left), .hs_right(hs_right), .ls_left(ls_left),
    .ls_right(ls_right), .prot_n(prot_n)
  );

  function automatic logic [3:0] gv();
    return {hs_left, hs_right, ls_left, ls_right};
  endfunction

  // expected pattern from the requirement tables
  function automatic logic [3:0] want(input logic [1:0] m, input logic neg);
    case (m)
      2'b00:   return neg ? 4'b0110 : 4'b1001;
      2'b10:   return neg ? 4'b1001 : 4'b0110;
      default: return 4'b0011;
    endcase
  endfunction

  // R9 monitor on every cycle
  always @(negedge clk) begin
    if (rst === 1'b0) begin
      if ((hs_left && ls_left) || (hs_right && ls_right)) shoot_bad++;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic request(input logic [1:0] m, input logic neg);
    @(negedge clk);
    mode_req = m;
    pol_neg  = neg;
  endtask

  // request already driven; expect DEAD off cycles then exp
  task automatic expect_transition(input logic [3:0] exp, input string tag);
    bit bad = 0;
    logic [3:0] seen = 4'b0000;
    for (int i = 0; i < DEAD; i++) begin
      @(negedge clk);
      if (gv() != 4'b0000) begin bad = 1; seen = gv(); end
    end
    chk(!bad, {tag, " dead interval"}, seen, 4'b0000);
    @(negedge clk);
    chk(gv() == exp, {tag, " new pattern"}, gv(), exp);
  endtask

  task automatic t_reset_R10();
    rst = 1; mode_req = 2'b00; pol_neg = 0; out_en = 1; fault = 0;
    repeat (3) @(negedge clk);
    chk(gv() == 4'b0000 && prot_n == 1'b1, "R10 reset state", {gv()}, 4'b0000);
    rst = 0;
    expect_transition(want(2'b00, 0), "R10 first request");
  endtask

  task automatic t_pos_R1();
    request(2'b01, 0);
    expect_transition(want(2'b01, 0), "R1 slow pos");
    request(2'b10, 0);
    expect_transition(want(2'b10, 0), "R1 fast pos");
    request(2'b00, 0);
    expect_transition(want(2'b00, 0), "R1 charge pos R4");
  endtask

  task automatic t_pol_R5();
    request(2'b00, 1);
    // old pattern must still hold one more edge is not visible: first negedge already off
    expect_transition(want(2'b00, 1), "R5 polarity flip charge");
  endtask

  task automatic t_neg_R2();
    request(2'b10, 1);
    expect_transition(want(2'b10, 1), "R2 fast neg");
    request(2'b01, 1);
    expect_transition(want(2'b01, 1), "R2 slow neg");
    request(2'b00, 1);
    expect_transition(want(2'b00, 1), "R2 charge neg");
  endtask

  task automatic t_code3_R3();
    request(2'b11, 0);
    expect_transition(4'b0011, "R3 code 11 pos");
    request(2'b11, 1);
    expect_transition(4'b0011, "R3 code 11 neg");
  endtask

  task automatic t_restart_R6();
    bit bad = 0;
    request(2'b10, 0);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (gv() != 4'b0000) bad = 1;
    end
    chk(!bad, "R6 off before restart", gv(), 4'b0000);
    mode_req = 2'b00;
    expect_transition(want(2'b00, 0), "R6 restarted interval");
  endtask

  task automatic t_enable_R7();
    bit bad = 0;
    @(negedge clk);
    chk(gv() == 4'b1001, "R7 steady before disable", gv(), 4'b1001);
    out_en = 0;
    @(negedge clk);
    chk(gv() == 4'b0000, "R7 off after disable", gv(), 4'b0000);
    mode_req = 2'b01;
    for (int i = 0; i < DEAD + 3; i++) begin
      @(negedge clk);
      if (gv() != 4'b0000) bad = 1;
    end
    chk(!bad, "R7 stays off while disabled", gv(), 4'b0000);
    out_en = 1;
    @(negedge clk);
    chk(gv() == 4'b0011, "R7 resume with elapsed dead time", gv(), 4'b0011);
  endtask

  task automatic t_fault_R8();
    bit bad = 0;
    fault = 1;
    @(negedge clk);
    chk(gv() == 4'b0000, "R8 gates off on fault", gv(), 4'b0000);
    chk(prot_n == 1'b0, "R8 protect low", {3'b000, prot_n}, 4'b0000);
    repeat (3) begin
      @(negedge clk);
      if (gv() != 4'b0000 || prot_n != 1'b0) bad = 1;
    end
    chk(!bad, "R8 held during fault", gv(), 4'b0000);
    fault = 0;
    @(negedge clk);
    chk(prot_n == 1'b1, "R8 protect released", {3'b000, prot_n}, 4'b0001);
    chk(gv() == 4'b0011, "R8 pattern resumes", gv(), 4'b0011);
  endtask

  initial begin
    t_reset_R10();
    t_pos_R1();
    t_pol_R5();
    t_neg_R2();
    t_code3_R3();
    t_restart_R6();
    t_enable_R7();
    t_fault_R8();
    chk(shoot_bad == 0, "R9 no leg shoot-through", 4'(shoot_bad), 4'b0000);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule